// File: doc/BRIEF.md
# Split TLB Address Translation Unit

This block turns a 32-bit virtual address into a physical address for one memory access per request. Instruction fetches take their execute right from a direct-mapped instruction TLB. Loads and stores take their read and write rights from a direct-mapped data TLB. Both TLBs are indexed by the same set number. Each set holds a match word, which carries the page tag and a valid flag, and a translate word, which carries the page frame and separate user and supervisor permission bits. Software fills the entries through a write port. Page-table walking is left to software, which acts on the miss codes.

Each accepted request gets a registered response one cycle later. The response carries the physical address, the granted permission mask and an exception code. The code tells a permission fault on a valid matching entry apart from a plain miss. When the code reports an exception, the block captures the faulting virtual address and pulses a signal that cancels any pending load-link reservation. When translation is switched off, addresses pass through unchanged with full rights.

Top module: `xlat_unit`

## Requirements
- R1: The set number used for both TLBs is `req_vaddr[18:13]`, the virtual page number reduced to its low 6 bits.
- R2: An entry hits only when match word bits [31:13] equal `req_vaddr[31:13]`. A request with no hit on the needed side reports a miss.
- R3: Bit 0 of a match word is its valid flag. A matching entry whose valid flag is clear grants nothing, and the needed side reports a miss.
- R4: The execute right, mask bit 2, comes from instruction translate word bit 7 in supervisor mode and from bit 6 in user mode. It is granted only on a valid hit in the instruction TLB.
- R5: The read right (mask bit 0) and the write right (mask bit 1) come from data translate word bits 8 and 9 in supervisor mode, and from bits 6 and 7 in user mode. They are granted only on a valid hit in the data TLB.
- R6: The physical address is translate word bits [31:13] joined with `req_vaddr[12:0]`. When the frames of the two translate words differ, the frame of the needed side is used.
- R7: `req_kind` is encoded as 0 fetch, 1 load, 2 store, and 3 is treated as a load. A fetch needs execute, a load needs read and a store needs write. `rsp_exc` is encoded as 0 none, 1 instruction page fault, 2 data page fault, 3 instruction TLB miss, 4 data TLB miss. A permission that is missing on a valid hit gives a page fault, and any other failure gives a miss.
- R8: When the frame bits [31:13] of the two translate words at a set differ, the side that the access does not need is disregarded and grants nothing in `rsp_perm`.
- R9: With `mmu_on` low, `rsp_paddr` equals the virtual address, `rsp_perm` is 3'b111 and `rsp_exc` is 0.
- R10: On a response with a nonzero exception code, `fault_addr` takes the request's virtual address and `resv_drop` is high for exactly that response cycle. On every other cycle `fault_addr` holds its value and `resv_drop` is low. After reset `fault_addr` is 0.
- R11: `rsp_valid` is high exactly in the cycle after a request is accepted (`req_valid && req_ready`) and low otherwise. It is low after reset.
- R12: A configuration write stores `cfg_data` into the word selected by `cfg_sel` (0 instruction match, 1 instruction translate, 2 data match, 3 data translate) at set `cfg_set`. While `cfg_we` is high, `req_ready` is low, so the write wins over a lookup. A lookup in the next cycle sees the written value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Lookup request present |
| req_ready | output | 1 | Lookup can be accepted this cycle |
| req_vaddr | input | 32 | Virtual address |
| req_kind | input | 2 | Access kind: 0 fetch, 1 load, 2 store |
| req_super | input | 1 | Supervisor mode flag |
| mmu_on | input | 1 | Translation enable |
| cfg_we | input | 1 | TLB word write strobe |
| cfg_sel | input | 2 | Word select: 0 imatch, 1 itrans, 2 dmatch, 3 dtrans |
| cfg_set | input | 6 | Set number to write |
| cfg_data | input | 32 | Word to write |
| rsp_valid | output | 1 | Response present |
| rsp_paddr | output | 32 | Physical address |
| rsp_perm | output | 3 | Granted rights {exec, write, read} |
| rsp_exc | output | 3 | Exception code |
| fault_addr | output | 32 | Last faulting virtual address |
| resv_drop | output | 1 | Reservation cancel pulse |

## Verification
The bench builds the block with its default values: 32-bit addresses, 13 offset bits and 64 sets. With these values the whole of both TLBs can be cleared and then refilled at random within a short run. Virtual pages are drawn from a small pool, so random stimulus often produces hits, tag mismatches on one set, invalid entries, and sets where the two frames disagree. The same random entries are read under user and supervisor mode and by all three access kinds.

// File: rtl/xlat_pkg.sv
package xlat_pkg;
  typedef enum logic [1:0] {
    ACC_FETCH = 2'd0,
    ACC_LOAD  = 2'd1,
    ACC_STORE = 2'd2,
    ACC_RSVD  = 2'd3
  } acc_kind_e;

  typedef enum logic [2:0] {
    EXC_NONE  = 3'd0,
    EXC_IPF   = 3'd1,
    EXC_DPF   = 3'd2,
    EXC_IMISS = 3'd3,
    EXC_DMISS = 3'd4
  } exc_code_e;

  // translate-word permission bit positions
  localparam int BIT_UX = 6;
  localparam int BIT_SX = 7;
  localparam int BIT_UR = 6;
  localparam int BIT_UW = 7;
  localparam int BIT_SR = 8;
  localparam int BIT_SW = 9;

  // granted mask layout
  localparam int PERM_R = 0;
  localparam int PERM_W = 1;
  localparam int PERM_X = 2;
endpackage

// File: rtl/tlb_array.sv
module tlb_array #(
  parameter int WORD_W   = 32,
  parameter int SET_BITS = 6
) (
  input  logic                clk,
  input  logic                we_match,
  input  logic                we_trans,
  input  logic [SET_BITS-1:0] wr_set,
  input  logic [WORD_W-1:0]   wr_data,
  input  logic [SET_BITS-1:0] rd_set,
  output logic [WORD_W-1:0]   rd_match,
  output logic [WORD_W-1:0]   rd_trans
);
  localparam int SETS = 1 << SET_BITS;

  logic [WORD_W-1:0] mem_match [SETS];
  logic [WORD_W-1:0] mem_trans [SETS];

  always_ff @(posedge clk) begin
    if (we_match) mem_match[wr_set] <= wr_data;
    if (we_trans) mem_trans[wr_set] <= wr_data;
  end

  assign rd_match = mem_match[rd_set];
  assign rd_trans = mem_trans[rd_set];
endmodule

// File: rtl/perm_eval.sv
module perm_eval
  import xlat_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int PAGE_BITS = 13
) (
  input  logic [ADDR_W-1:0] vaddr,
  input  logic [1:0]        kind,
  input  logic              sup,
  input  logic [ADDR_W-1:0] imatch,
  input  logic [ADDR_W-1:0] itrans,
  input  logic [ADDR_W-1:0] dmatch,
  input  logic [ADDR_W-1:0] dtrans,
  output logic [ADDR_W-1:0] paddr,
  output logic [2:0]        perm,
  output logic [2:0]        exc
);
  logic need_x, need_w, need_r;
  logic [ADDR_W-1:0] i_m, i_t, d_m, d_t;
  logic valid_x, valid_rw;
  logic [2:0] need_mask;
  logic unused_bits;

  always_comb begin
    need_x = (kind == ACC_FETCH);
    need_w = (kind == ACC_STORE);
    need_r = !need_x && !need_w;
    need_mask = '0;
    need_mask[PERM_X] = need_x;
    need_mask[PERM_W] = need_w;
    need_mask[PERM_R] = need_r;

    i_m = imatch;
    i_t = itrans;
    d_m = dmatch;
    d_t = dtrans;
    // frames disagree: keep only the side this access needs
    if (itrans[ADDR_W-1:PAGE_BITS] != dtrans[ADDR_W-1:PAGE_BITS]) begin
      if (need_x) begin
        d_m = '0;
        d_t = '0;
      end else begin
        i_m = '0;
        i_t = '0;
      end
    end

    valid_x  = i_m[0] && (i_m[ADDR_W-1:PAGE_BITS] == vaddr[ADDR_W-1:PAGE_BITS]);
    valid_rw = d_m[0] && (d_m[ADDR_W-1:PAGE_BITS] == vaddr[ADDR_W-1:PAGE_BITS]);

    perm = '0;
    perm[PERM_X] = valid_x  && (sup ? i_t[BIT_SX] : i_t[BIT_UX]);
    perm[PERM_R] = valid_rw && (sup ? d_t[BIT_SR] : d_t[BIT_UR]);
    perm[PERM_W] = valid_rw && (sup ? d_t[BIT_SW] : d_t[BIT_UW]);

    paddr = {(i_t[ADDR_W-1:PAGE_BITS] | d_t[ADDR_W-1:PAGE_BITS]),
             vaddr[PAGE_BITS-1:0]};

    if (|(need_mask & perm))  exc = EXC_NONE;
    else if (need_x)          exc = valid_x  ? EXC_IPF : EXC_IMISS;
    else                      exc = valid_rw ? EXC_DPF : EXC_DMISS;
  end

  assign unused_bits = ^{i_m, i_t, d_m, d_t};
endmodule

// File: rtl/xlat_unit.sv
module xlat_unit
  import xlat_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int PAGE_BITS = 13,
  parameter int SET_BITS  = 6
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                req_valid,
  output logic                req_ready,
  input  logic [ADDR_W-1:0]   req_vaddr,
  input  logic [1:0]          req_kind,
  input  logic                req_super,
  input  logic                mmu_on,
  input  logic                cfg_we,
  input  logic [1:0]          cfg_sel,
  input  logic [SET_BITS-1:0] cfg_set,
  input  logic [ADDR_W-1:0]   cfg_data,
  output logic                rsp_valid,
  output logic [ADDR_W-1:0]   rsp_paddr,
  output logic [2:0]          rsp_perm,
  output logic [2:0]          rsp_exc,
  output logic [ADDR_W-1:0]   fault_addr,
  output logic                resv_drop
);
  localparam int NUM_SIDES = 2;  // 0 instruction, 1 data

  logic [SET_BITS-1:0] rd_set;
  logic [ADDR_W-1:0]   side_match [NUM_SIDES];
  logic [ADDR_W-1:0]   side_trans [NUM_SIDES];
  logic                accept;
  logic [ADDR_W-1:0]   xl_paddr;
  logic [2:0]          xl_perm, xl_exc;
  logic [ADDR_W-1:0]   nx_paddr;
  logic [2:0]          nx_perm, nx_exc;

  assign req_ready = !cfg_we;
  assign accept    = req_valid && req_ready;
  assign rd_set    = req_vaddr[PAGE_BITS +: SET_BITS];

  for (genvar s = 0; s < NUM_SIDES; s++) begin : g_side
    tlb_array #(
      .WORD_W  (ADDR_W),
      .SET_BITS(SET_BITS)
    ) u_tlb (
      .clk     (clk),
      .we_match(cfg_we && (cfg_sel == 2'(2 * s))),
      .we_trans(cfg_we && (cfg_sel == 2'(2 * s + 1))),
      .wr_set  (cfg_set),
      .wr_data (cfg_data),
      .rd_set  (rd_set),
      .rd_match(side_match[s]),
      .rd_trans(side_trans[s])
    );
  end

  perm_eval #(
    .ADDR_W   (ADDR_W),
    .PAGE_BITS(PAGE_BITS)
  ) u_eval (
    .vaddr (req_vaddr),
    .kind  (req_kind),
    .sup   (req_super),
    .imatch(side_match[0]),
    .itrans(side_trans[0]),
    .dmatch(side_match[1]),
    .dtrans(side_trans[1]),
    .paddr (xl_paddr),
    .perm  (xl_perm),
    .exc   (xl_exc)
  );

  always_comb begin
    if (mmu_on) begin
      nx_paddr = xl_paddr;
      nx_perm  = xl_perm;
      nx_exc   = xl_exc;
    end else begin
      nx_paddr = req_vaddr;
      nx_perm  = 3'b111;
      nx_exc   = EXC_NONE;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid  <= 1'b0;
      rsp_paddr  <= '0;
      rsp_perm   <= '0;
      rsp_exc    <= EXC_NONE;
      fault_addr <= '0;
      resv_drop  <= 1'b0;
    end else begin
      rsp_valid <= accept;
      resv_drop <= accept && (nx_exc != EXC_NONE);
      if (accept) begin
        rsp_paddr <= nx_paddr;
        rsp_perm  <= nx_perm;
        rsp_exc   <= nx_exc;
        if (nx_exc != EXC_NONE) fault_addr <= req_vaddr;
      end
    end
  end

  // R11: exactly one response per accepted request, one cycle later
  p_rsp_timing_r11: assert property (@(posedge clk) disable iff (rst)
    accept |=> rsp_valid);
  p_rsp_idle_r11: assert property (@(posedge clk) disable iff (rst)
    !accept |=> !rsp_valid);

  // R12: configuration write blocks a lookup
  p_cfg_priority_r12: assert property (@(posedge clk) disable iff (rst)
    cfg_we |-> !req_ready);

  // R9: bypass when translation is off
  p_bypass_r9: assert property (@(posedge clk) disable iff (rst)
    (accept && !mmu_on) |=> (rsp_exc == EXC_NONE && rsp_perm == 3'b111
                             && rsp_paddr == $past(req_vaddr)));

  // R6: page offset always passes through
  p_offset_r6: assert property (@(posedge clk) disable iff (rst)
    accept |=> rsp_paddr[PAGE_BITS-1:0] == $past(req_vaddr[PAGE_BITS-1:0]));

  // R10: fault capture and reservation drop
  p_fault_latch_r10: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_exc != EXC_NONE) |-> (resv_drop && fault_addr == $past(req_vaddr)));
  p_resv_only_on_exc_r10: assert property (@(posedge clk) disable iff (rst)
    resv_drop |-> (rsp_valid && rsp_exc != EXC_NONE));
  p_fault_hold_r10: assert property (@(posedge clk) disable iff (rst)
    !resv_drop |=> (resv_drop || $stable(fault_addr)));

  // R7: exception code range, success grants the needed right
  p_exc_range_r7: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> rsp_exc <= EXC_DMISS);
endmodule

// File: tb/xlat_unit_tb.sv
`timescale 1ns/1ps
module xlat_unit_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_vaddr = '0;
  logic [1:0]  req_kind = '0;
  logic        req_super = 1'b0;
  logic        mmu_on = 1'b1;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_sel = '0;
  logic [5:0]  cfg_set = '0;
  logic [31:0] cfg_data = '0;
  logic        rsp_valid;
  logic [31:0] rsp_paddr;
  logic [2:0]  rsp_perm;
  logic [2:0]  rsp_exc;
  logic [31:0] fault_addr;
  logic        resv_drop;

  int n_chk = 0;
  int n_bad = 0;
  logic [31:0] m_word [4][64];
  logic [31:0] m_fault = '0;

  always #5 clk = ~clk;

  xlat_unit u_dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_vaddr(req_vaddr), .req_kind(req_kind), .req_super(req_super),
    .mmu_on(mmu_on), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_set(cfg_set),
    .cfg_data(cfg_data), .rsp_valid(rsp_valid), .rsp_paddr(rsp_paddr),
    .rsp_perm(rsp_perm), .rsp_exc(rsp_exc), .fault_addr(fault_addr),
    .resv_drop(resv_drop)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // expected response computed from the requirements
  function automatic void model(input logic [31:0] va, input logic [1:0] kind,
                                input logic sup, input logic on,
                                output logic [31:0] pa, output logic [2:0] pm,
                                output logic [2:0] ex);
    logic [5:0]  set;
    logic [31:0] im, it, dm, dt;
    logic        nx, nw, vx, vd;
    set = va[18:13];                    // R1
    im = m_word[0][set]; it = m_word[1][set];
    dm = m_word[2][set]; dt = m_word[3][set];
    nx = (kind == 2'd0);
    nw = (kind == 2'd2);
    if (!on) begin                      // R9
      pa = va; pm = 3'b111; ex = 3'd0;
      return;
    end
    if (it[31:13] != dt[31:13]) begin   // R8
      if (nx) begin dm = 0; dt = 0; end
      else begin im = 0; it = 0; end
    end
    vx = im[0] && (im[31:13] == va[31:13]);   // R2 R3
    vd = dm[0] && (dm[31:13] == va[31:13]);
    pm[2] = vx && (sup ? it[7] : it[6]);      // R4
    pm[0] = vd && (sup ? dt[8] : dt[6]);      // R5
    pm[1] = vd && (sup ? dt[9] : dt[7]);
    pa = {(nx ? it[31:13] : dt[31:13]), va[12:0]};  // R6
    if ((nx && pm[2]) || (nw && pm[1]) || (!nx && !nw && pm[0])) ex = 3'd0;
    else if (nx) ex = vx ? 3'd1 : 3'd3;       // R7
    else         ex = vd ? 3'd2 : 3'd4;
  endfunction

  task automatic cfg_write(input logic [1:0] sel, input logic [5:0] set, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = sel; cfg_set = set; cfg_data = d;
    m_word[sel][set] = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic lookup(input string tag, input logic [31:0] va, input logic [1:0] kind,
                        input logic sup, input logic on);
    logic [31:0] pa; logic [2:0] pm, ex;
    model(va, kind, sup, on, pa, pm, ex);
    @(negedge clk);
    req_valid = 1'b1; req_vaddr = va; req_kind = kind; req_super = sup; mmu_on = on;
    @(negedge clk);
    req_valid = 1'b0;
    if (ex != 3'd0) m_fault = va;
    chk({tag, " R11 rsp_valid"}, 32'(rsp_valid), 32'd1);
    chk({tag, " R6 paddr"}, rsp_paddr, pa);
    chk({tag, " R4/R5 perm"}, 32'(rsp_perm), 32'(pm));
    chk({tag, " R7 exc"}, 32'(rsp_exc), 32'(ex));
    chk({tag, " R10 fault_addr"}, fault_addr, m_fault);
    chk({tag, " R10 resv_drop"}, 32'(resv_drop), 32'(ex != 3'd0));
    @(negedge clk);
    chk({tag, " R11 rsp idle"}, 32'(rsp_valid), 32'd0);
    chk({tag, " R10 resv_drop low"}, 32'(resv_drop), 32'd0);
  endtask

  logic [31:0] pool [8];

  initial begin
    logic [31:0] va, w;
    logic [5:0]  s;
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    #1;
    chk("R11 reset rsp_valid", 32'(rsp_valid), 32'd0);
    chk("R10 reset fault_addr", fault_addr, 32'd0);
    chk("R10 reset resv_drop", 32'(resv_drop), 32'd0);
    chk("R12 reset req_ready", 32'(req_ready), 32'd1);

    for (int k = 0; k < 4; k++)
      for (int j = 0; j < 64; j++) cfg_write(2'(k), 6'(j), 32'd0);

    // directed: empty TLB misses (R3), bypass (R9)
    lookup("empty fetch R3", 32'h0000_4123, 2'd0, 1'b0, 1'b1);
    lookup("empty store R3", 32'h0000_4123, 2'd2, 1'b1, 1'b1);
    lookup("bypass R9", 32'hDEAD_BEEF, 2'd2, 1'b0, 1'b0);

    // directed: set 5 maps page 0x12345 (set = 0x05) to frame 0x00ABC
    va = {19'h12345, 13'h0777};
    s  = va[18:13];
    cfg_write(2'd0, s, {19'h12345, 12'h0, 1'b1});
    cfg_write(2'd1, s, {19'h00ABC, 13'b0_0000_1000_0000});  // SX only
    cfg_write(2'd2, s, {19'h12345, 12'h0, 1'b1});
    cfg_write(2'd3, s, {19'h00ABC, 13'b0_0011_0100_0000}); // UR, SR, SW
    lookup("super fetch R4", va, 2'd0, 1'b1, 1'b1);
    lookup("user fetch fault R4", va, 2'd0, 1'b0, 1'b1);
    lookup("user load R5", va, 2'd1, 1'b0, 1'b1);
    lookup("user store fault R5", va, 2'd2, 1'b0, 1'b1);
    lookup("super store R5", va, 2'd2, 1'b1, 1'b1);
    lookup("tag mismatch R2", va ^ 32'h8000_0000, 2'd1, 1'b1, 1'b1);
    // R8: differing frames, instruction side disregarded for loads
    cfg_write(2'd1, s, {19'h00ABD, 13'b0_0000_1100_0000});
    lookup("frame split load R8", va, 2'd1, 1'b1, 1'b1);
    lookup("frame split fetch R8", va, 2'd0, 1'b1, 1'b1);
    // R3: clear valid bit on data side
    cfg_write(2'd2, s, {19'h12345, 12'hFFF, 1'b0});
    lookup("invalid data R3", va, 2'd1, 1'b1, 1'b1);

    // R12: write and lookup in the same cycle
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = 2'd2; cfg_set = s; cfg_data = {19'h12345, 12'h0, 1'b1};
    m_word[2][s] = cfg_data;
    req_valid = 1'b1; req_vaddr = va; req_kind = 2'd1; req_super = 1'b1; mmu_on = 1'b1;
    #1;
    chk("R12 ready low during write", 32'(req_ready), 32'd0);
    @(negedge clk);
    cfg_we = 1'b0; req_valid = 1'b0;
    chk("R12 no response to blocked lookup", 32'(rsp_valid), 32'd0);
    lookup("R12 write visible", va, 2'd1, 1'b1, 1'b1);

    // random phase
    for (int j = 0; j < 8; j++) pool[j] = $urandom;
    for (int n = 0; n < 400; n++) begin
      va = pool[$urandom % 8] ^ 32'($urandom % 8192);
      if (($urandom % 4) == 0) va[18:13] = 6'($urandom);
      s = va[18:13];
      if (($urandom % 3) == 0) begin
        w = {va[31:13], 12'($urandom), 1'(($urandom % 4) != 0)};
        if (($urandom % 6) == 0) w[31] = ~w[31];
        cfg_write(2'd0, s, w);
        w = {va[31:13], 12'($urandom), 1'(($urandom % 4) != 0)};
        if (($urandom % 6) == 0) w[30] = ~w[30];
        cfg_write(2'd2, s, w);
        w = $urandom;
        cfg_write(2'd1, s, w);
        if (($urandom % 4) != 0) w = {w[31:13], 13'($urandom)};
        else w = $urandom;
        cfg_write(2'd3, s, w);
      end
      lookup("random R1", va, 2'($urandom % 4), 1'($urandom), (($urandom % 10) != 0));
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #1_500_000;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule